// File: doc/BRIEF.md
# Nearest-Frequency PLL Divider Search

This block picks the programming word for a clock synthesizer whose output frequency must come as close as possible to a requested pixel rate. The reference is fixed at 14.31818 MHz. A request arrives as a 16-bit frequency in units of 0.01 MHz together with a one-cycle `start`. The block clamps the request to the supported band and derives a power-of-two post-divider exponent. It then walks every feedback/reference divider pair, one candidate after another, and keeps the pair whose scaled output frequency has the smallest absolute distance from the scaled target. When the walk ends, it pulses `done` and presents a 16-bit word that holds the winning dividers and the exponent.

Candidate frequencies and the target are compared in fixed point scaled by 256. All quotients come from one shared multi-bit-per-cycle sequential divider. The controller is a seven-state machine. `S_IDLE` waits for `start` and moves to `S_FINISH` for a zero request, or to `S_TGT_GO` otherwise. `S_TGT_GO` launches the target division and moves to `S_TGT_WAIT`, which moves to `S_CAND_GO` when the quotient is ready. `S_CAND_GO` launches one candidate division and moves to `S_CAND_WAIT`, which moves to `S_CAND_CMP` when the quotient is ready. `S_CAND_CMP` returns to `S_CAND_GO` until the last pair is done, then moves to `S_FINISH`. `S_FINISH` returns to `S_IDLE`.

Top module: `pll_mn_search`

## Requirements
- R1: A request of zero skips the search: `done` is high in the cycle right after the `start` cycle, `busy` stays low, and the word is 0x00E0.
- R2: A nonzero request below 8000 is treated exactly as a request of 8000.
- R3: A request above 15938 is treated exactly as a request of 15938.
- R4: The target is floor(clamped request × 256 / 100).
- R5: The exponent k is the number of doublings the clamped request needs to reach at least 64000, and it appears in word bits [7:6].
- R6: M takes the values 2 to 30 and N takes the values 35 to 247, with N stepping fastest. The word holds N in bits [15:8] and M in bits [5:0].
- R7: A candidate's scaled frequency is floor(938356 × (N+8) / (2^k × 256 × (M+2))).
- R8: A candidate becomes the best one only when its absolute error from the target is strictly smaller than the best so far, so on a tie the earlier candidate in walk order is kept. The best error starts at all ones.
- R9: For a nonzero request, `busy` is high from the cycle after `start` until the search ends. `done` is then high for exactly one cycle, with `busy` low, and the word changes only in a cycle where `done` is high.
- R10: A `start` received while `busy` is high is ignored: the running search neither restarts nor ends early, and its result is unchanged.
- R11: During reset `busy` and `done` are low and the word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe, honoured only when idle |
| req_freq | input | 16 | Requested frequency in 0.01 MHz units |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| prog_word | output | 16 | Result word: N in [15:8], k in [7:6], M in [5:0] |

## Verification
The bench drives a zero request. A design that searched anyway, or that mistimed the shortcut, would return late or return a word other than 0x00E0. It also sends requests far below and far above the band. A missing or off-by-one clamp would produce a different winner, and at the top the target lies above every candidate, so only the largest candidate frequency is correct. A mid-band request exercises the full walk with strict-less selection. Choosing the later candidate on a tie, rounding the quotient, or skipping the last N or M value changes the word that wins. While that search runs, a zero request is also pulsed in: a design that listened would finish early with 0x00E0.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TGT_GO,
        S_TGT_WAIT,
        S_CAND_GO,
        S_CAND_WAIT,
        S_CAND_CMP,
        S_FINISH
    } srch_state_t;

endpackage

// File: rtl/pllsrch_prep.sv
module pllsrch_prep #(
    parameter int REQ_W     = 16,
    parameter int F_MIN     = 8000,
    parameter int F_MAX     = 15938,
    parameter int F_VCO_MIN = 64000,
    parameter int K_MAX     = 3,
    parameter int K_W       = 2
) (
    input  logic [REQ_W-1:0] req,
    output logic [REQ_W-1:0] clamped,
    output logic [K_W-1:0]   k,
    output logic             is_zero
);
    localparam int VW = REQ_W + K_MAX;
    localparam logic [REQ_W-1:0] LO_V  = REQ_W'(F_MIN);
    localparam logic [REQ_W-1:0] HI_V  = REQ_W'(F_MAX);
    localparam logic [VW-1:0]    VCO_V = VW'(F_VCO_MIN);

    always_comb begin
        logic [VW-1:0] v;
        if (req < LO_V)      clamped = LO_V;
        else if (req > HI_V) clamped = HI_V;
        else                 clamped = req;
        v = VW'(clamped);
        k = '0;
        for (int i = 0; i < K_MAX; i++) begin
            if (v < VCO_V) begin
                v = v << 1;
                k = k + K_W'(1);
            end
        end
        is_zero = (req == '0);
    end

endmodule

// File: rtl/pllsrch_cand.sv
module pllsrch_cand #(
    parameter int REF_SCALED  = 938356,
    parameter int N_W         = 8,
    parameter int M_W         = 6,
    parameter int K_W         = 2,
    parameter int N_OFFSET    = 8,
    parameter int M_OFFSET    = 2,
    parameter int SCALE_SHIFT = 8,
    parameter int DIV_W       = 24,
    parameter int DVS_W       = 7
) (
    input  logic [N_W-1:0]   n,
    input  logic [M_W-1:0]   m,
    input  logic [K_W-1:0]   k,
    output logic [DIV_W-1:0] dividend,
    output logic [DVS_W-1:0] divisor
);
    localparam int REF_W  = $clog2(REF_SCALED + 1);
    localparam int NUM_W  = REF_W + N_W + 1;
    localparam int SH_W   = 6;

    logic [N_W:0]     n_sum;
    logic [NUM_W-1:0] num;
    logic [SH_W-1:0]  sh;

    // floor(floor(a / 2^s) / b) equals floor(a / (2^s * b)), so the power-of-two
    // part of the denominator is a shift and only (M+2) goes to the divider.
    assign n_sum    = {1'b0, n} + (N_W+1)'(N_OFFSET);
    assign num      = NUM_W'(REF_SCALED) * NUM_W'(n_sum);
    assign sh       = SH_W'(SCALE_SHIFT) + SH_W'(k);
    assign dividend = DIV_W'(num >> sh);
    assign divisor  = DVS_W'(m) + DVS_W'(M_OFFSET);

endmodule

// File: rtl/pllsrch_div.sv
module pllsrch_div #(
    parameter int DIV_W = 24,
    parameter int DVS_W = 7,
    parameter int STEP  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DIV_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic [DIV_W-1:0] quotient,
    output logic             fin
);
    localparam int ITERS = DIV_W / STEP;
    localparam int CNT_W = $clog2(ITERS + 1);
    localparam int REM_W = DVS_W + 1;

    logic [DIV_W-1:0] q_r, q_n;
    logic [REM_W-1:0] r_r, r_n;
    logic [DVS_W-1:0] d_r;
    logic [CNT_W-1:0] cnt_r;
    logic             fin_r;

    // STEP restoring-division stages unrolled per clock
    always_comb begin
        q_n = q_r;
        r_n = r_r;
        for (int s = 0; s < STEP; s++) begin
            r_n = {r_n[REM_W-2:0], q_n[DIV_W-1]};
            q_n = {q_n[DIV_W-2:0], 1'b0};
            if (r_n >= {1'b0, d_r}) begin
                r_n    = r_n - {1'b0, d_r};
                q_n[0] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r   <= '0;
            r_r   <= '0;
            d_r   <= '0;
            cnt_r <= '0;
            fin_r <= 1'b0;
        end else if (go) begin
            q_r   <= dividend;
            r_r   <= '0;
            d_r   <= divisor;
            cnt_r <= CNT_W'(ITERS);
            fin_r <= 1'b0;
        end else if (cnt_r != '0) begin
            q_r   <= q_n;
            r_r   <= r_n;
            cnt_r <= cnt_r - CNT_W'(1);
            fin_r <= (cnt_r == CNT_W'(1));
        end else begin
            fin_r <= 1'b0;
        end
    end

    assign quotient = q_r;
    assign fin      = fin_r;

endmodule

// File: rtl/pll_mn_search.sv
module pll_mn_search
    import pllsrch_pkg::*;
#(
    parameter int REQ_W      = 16,
    parameter int WORD_W     = 16,
    parameter int N_SHIFT    = 8,
    parameter int K_SHIFT    = 6,
    parameter int F_MIN      = 8000,
    parameter int F_MAX      = 15938,
    parameter int F_VCO_MIN  = 64000,
    parameter int K_MAX      = 3,
    parameter int M_LO       = 2,
    parameter int M_HI       = 30,
    parameter int N_LO       = 35,
    parameter int N_HI       = 247,
    parameter int REF_SCALED = 938356,
    parameter int TGT_SCALE  = 256,
    parameter int TGT_DIV    = 100,
    parameter int ZERO_WORD  = 224,
    parameter int DIV_W      = 24,
    parameter int DVS_W      = 7,
    parameter int DIV_STEP   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REQ_W-1:0]  req_freq,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] prog_word
);
    localparam int M_W = K_SHIFT;
    localparam int K_W = N_SHIFT - K_SHIFT;
    localparam int N_W = WORD_W - N_SHIFT;
    localparam logic [M_W-1:0]    M_LO_V = M_W'(M_LO);
    localparam logic [M_W-1:0]    M_HI_V = M_W'(M_HI);
    localparam logic [N_W-1:0]    N_LO_V = N_W'(N_LO);
    localparam logic [N_W-1:0]    N_HI_V = N_W'(N_HI);
    localparam logic [WORD_W-1:0] ZERO_V = WORD_W'(ZERO_WORD);

    srch_state_t state_q, state_d;

    logic [REQ_W-1:0]  clamp_w, clamp_q;
    logic [K_W-1:0]    k_w, k_q;
    logic              zero_w;
    logic [DIV_W-1:0]  tgt_q, fout_q, best_err_q;
    logic [M_W-1:0]    m_q, best_m_q, nb_m;
    logic [N_W-1:0]    n_q, best_n_q, nb_n;
    logic [WORD_W-1:0] word_q;

    logic [DIV_W-1:0]  cand_dividend, div_dividend, div_quo, err_w;
    logic [DVS_W-1:0]  cand_divisor, div_divisor;
    logic              div_go, div_fin, better_w, last_n, last_m;

    pllsrch_prep #(
        .REQ_W(REQ_W), .F_MIN(F_MIN), .F_MAX(F_MAX),
        .F_VCO_MIN(F_VCO_MIN), .K_MAX(K_MAX), .K_W(K_W)
    ) i_prep (
        .req(req_freq), .clamped(clamp_w), .k(k_w), .is_zero(zero_w)
    );

    pllsrch_cand #(
        .REF_SCALED(REF_SCALED), .N_W(N_W), .M_W(M_W), .K_W(K_W),
        .N_OFFSET(8), .M_OFFSET(2), .SCALE_SHIFT($clog2(TGT_SCALE)),
        .DIV_W(DIV_W), .DVS_W(DVS_W)
    ) i_cand (
        .n(n_q), .m(m_q), .k(k_q),
        .dividend(cand_dividend), .divisor(cand_divisor)
    );

    pllsrch_div #(
        .DIV_W(DIV_W), .DVS_W(DVS_W), .STEP(DIV_STEP)
    ) i_div (
        .clk(clk), .rst_n(rst_n), .go(div_go),
        .dividend(div_dividend), .divisor(div_divisor),
        .quotient(div_quo), .fin(div_fin)
    );

    // one shared divider: target first, then one candidate at a time
    assign div_go       = (state_q == S_TGT_GO) || (state_q == S_CAND_GO);
    assign div_dividend = (state_q == S_TGT_GO) ? DIV_W'(clamp_q) * DIV_W'(TGT_SCALE)
                                                : cand_dividend;
    assign div_divisor  = (state_q == S_TGT_GO) ? DVS_W'(TGT_DIV) : cand_divisor;

    assign err_w    = (tgt_q > fout_q) ? (tgt_q - fout_q) : (fout_q - tgt_q);
    assign better_w = (err_w < best_err_q);
    assign nb_m     = better_w ? m_q : best_m_q;
    assign nb_n     = better_w ? n_q : best_n_q;
    assign last_n   = (n_q == N_HI_V);
    assign last_m   = (m_q == M_HI_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_d = zero_w ? S_FINISH : S_TGT_GO;
            S_TGT_GO:    state_d = S_TGT_WAIT;
            S_TGT_WAIT:  if (div_fin) state_d = S_CAND_GO;
            S_CAND_GO:   state_d = S_CAND_WAIT;
            S_CAND_WAIT: if (div_fin) state_d = S_CAND_CMP;
            S_CAND_CMP:  state_d = (last_n && last_m) ? S_FINISH : S_CAND_GO;
            S_FINISH:    state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clamp_q    <= '0;
            k_q        <= '0;
            tgt_q      <= '0;
            fout_q     <= '0;
            best_err_q <= '1;
            m_q        <= '0;
            n_q        <= '0;
            best_m_q   <= '0;
            best_n_q   <= '0;
            word_q     <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        clamp_q <= clamp_w;
                        k_q     <= k_w;
                        if (zero_w) word_q <= ZERO_V;
                    end
                end
                S_TGT_WAIT: begin
                    if (div_fin) begin
                        tgt_q      <= div_quo;
                        m_q        <= M_LO_V;
                        n_q        <= N_LO_V;
                        best_err_q <= '1;
                        best_m_q   <= M_LO_V;
                        best_n_q   <= N_LO_V;
                    end
                end
                S_CAND_WAIT: begin
                    if (div_fin) fout_q <= div_quo;
                end
                S_CAND_CMP: begin
                    if (better_w) begin
                        best_err_q <= err_w;
                        best_m_q   <= m_q;
                        best_n_q   <= n_q;
                    end
                    if (last_n) begin
                        n_q <= N_LO_V;
                        if (last_m) word_q <= {nb_n, k_q, nb_m};
                        else        m_q    <= m_q + M_W'(1);
                    end else begin
                        n_q <= n_q + N_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q != S_IDLE) && (state_q != S_FINISH);
        done      = (state_q == S_FINISH);
        prog_word = word_q;
    end

endmodule

// File: rtl/pllsrch_chk.sv
module pllsrch_chk #(
    parameter int REQ_W     = 16,
    parameter int WORD_W    = 16,
    parameter int N_SHIFT   = 8,
    parameter int K_SHIFT   = 6,
    parameter int M_LO      = 2,
    parameter int M_HI      = 30,
    parameter int N_LO      = 35,
    parameter int N_HI      = 247,
    parameter int ZERO_WORD = 224
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [REQ_W-1:0]  req_freq,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] prog_word
);
    localparam int M_W = K_SHIFT;
    localparam int N_W = WORD_W - N_SHIFT;
    localparam logic [M_W-1:0]    M_LO_V = M_W'(M_LO);
    localparam logic [M_W-1:0]    M_HI_V = M_W'(M_HI);
    localparam logic [N_W-1:0]    N_LO_V = N_W'(N_LO);
    localparam logic [N_W-1:0]    N_HI_V = N_W'(N_HI);
    localparam logic [WORD_W-1:0] ZERO_V = WORD_W'(ZERO_WORD);

    AST_ZERO_SHORTCUT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && req_freq == '0) |=> (done && !busy && prog_word == ZERO_V)); // R1

    AST_FIELDS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && prog_word != ZERO_V) |->
            (prog_word[WORD_W-1:N_SHIFT] >= N_LO_V && prog_word[WORD_W-1:N_SHIFT] <= N_HI_V &&
             prog_word[M_W-1:0] >= M_LO_V && prog_word[M_W-1:0] <= M_HI_V)); // R6

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && req_freq != '0) |=> busy); // R9

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R9

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(prog_word)); // R9

    AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done)); // R10

    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R9

endmodule

bind pll_mn_search pllsrch_chk #(
    .REQ_W(REQ_W), .WORD_W(WORD_W), .N_SHIFT(N_SHIFT), .K_SHIFT(K_SHIFT),
    .M_LO(M_LO), .M_HI(M_HI), .N_LO(N_LO), .N_HI(N_HI), .ZERO_WORD(ZERO_WORD)
) i_pllsrch_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .req_freq(req_freq),
    .busy(busy), .done(done), .prog_word(prog_word)
);

// File: tb/test_pll_mn_search.sv
module test_pll_mn_search;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] req_freq = '0;
    logic        busy, done;
    logic [15:0] prog_word;

    int n_checks = 0;
    int n_errs   = 0;

    logic [15:0] expq[$];
    string       tagq[$];

    always #10 clk = ~clk;  // 50 MHz

    pll_mn_search i_pll_mn_search (
        .clk(clk), .rst_n(rst_n), .start(start), .req_freq(req_freq),
        .busy(busy), .done(done), .prog_word(prog_word)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // reference: clamp (R2 R3), target (R4), exponent (R5), walk (R6),
    // candidate (R7), strict-less pick (R8)
    function automatic logic [15:0] model(input int req);
        longint c, v, tgt, f, d, best;
        int k, bm, bn;
        if (req == 0) return 16'h00E0;
        c = req;
        if (c < 8000)  c = 8000;
        if (c > 15938) c = 15938;
        tgt = (c * 256) / 100;
        k = 0;
        v = c;
        while (v < 64000) begin
            v = v * 2;
            k++;
        end
        best = longint'(1) << 40;
        bm = 0;
        bn = 0;
        for (int m = 2; m <= 30; m++) begin
            for (int n = 35; n <= 247; n++) begin
                f = (longint'(938356) * (n + 8)) / ((longint'(1) << k) * 256 * (m + 2));
                d = (f > tgt) ? f - tgt : tgt - f;
                if (d < best) begin
                    best = d;
                    bm = m;
                    bn = n;
                end
            end
        end
        return 16'((bn << 8) + (k << 6) + bm);
    endfunction

    // monitor: pop the scoreboard on every result strobe
    always @(negedge clk) begin
        logic [15:0] e;
        string t;
        if (rst_n && done) begin
            if (expq.size() == 0) begin
                check(1'b0, "R9", "done with no request pending", 1, 0);
            end else begin
                e = expq.pop_front();
                t = tagq.pop_front();
                check(prog_word == e, t, "prog_word", prog_word, e);
            end
        end
    end

    task automatic run_req(input int req, input string tag, input bit poke);
        expq.push_back(model(req));
        tagq.push_back(tag);
        @(negedge clk);
        start = 1'b1;
        req_freq = 16'(req);
        @(negedge clk);
        start = 1'b0;
        if (req == 0) begin
            check(done == 1'b1, "R1", "done right after start", done, 1);
            check(busy == 1'b0, "R1", "busy on zero request", busy, 0);
        end else begin
            check(busy == 1'b1, "R9", "busy after start", busy, 1);
        end
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            req_freq = 16'h0000;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            check(busy == 1'b1 && done == 1'b0, "R10", "search kept running",
                  {busy, done}, 2'b10);
        end
        while (!done) @(negedge clk);
        if (req != 0) begin
            check(prog_word[7:6] == 2'd3, "R5", "k field", prog_word[7:6], 3);
            check(prog_word[15:8] >= 8'd35 && prog_word[15:8] <= 8'd247, "R6",
                  "N field range", prog_word[15:8], 35);
            check(prog_word[5:0] >= 6'd2 && prog_word[5:0] <= 6'd30, "R6",
                  "M field range", prog_word[5:0], 2);
        end
        @(negedge clk);
        check(done == 1'b0, "R9", "done lasts one cycle", done, 0);
        check(busy == 1'b0, "R9", "idle after done", busy, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL R9 watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R11", "busy in reset", busy, 0);
        check(done == 1'b0, "R11", "done in reset", done, 0);
        check(prog_word == 16'h0000, "R11", "word in reset", prog_word, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_req(10000, "R4 R7 R8", 1'b1);   // mid band, with a start poked in (R10)
        run_req(0, "R1", 1'b0);             // zero shortcut
        run_req(3, "R2", 1'b0);             // below band: same as 8000
        run_req(60000, "R3", 1'b0);         // above band: same as 15938

        repeat (2) @(negedge clk);
        check(expq.size() == 0, "R9", "all results delivered", expq.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule